// File: doc/BRIEF.md
# Proportional Transmit Phase Controller

This block closes a proportional loop around the delay of a transmitter. Each
measurement arrives as a set of time tags: the tag of the detected RF pulse edge,
plus the tags of three candidate reference edges. The reference edges are the
transmission timing event derived from the UTC timebase, the same event derived
from the received-signal timebase, and the RF gate. A configuration field picks
one reference. The block subtracts the chosen reference tag from the pulse tag to
form a signed timing error.

The error passes through three independent controls. A power-of-two time constant
scales the correction down. A minimum-steer dead band discards small errors. A
minimum spacing, counted in accepted samples, limits how often a correction may
go out. When all three allow it, the block raises a one-cycle adjustment request
with a signed amount. The amount goes to the phase slewing block, which applies
it through the same frequency-offset path used for manual phase moves. Two status
flags report whether the last sample fell inside the dead band or was held back by
the spacing limit.

Top module: `ptc_steer_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `steer_req`, `steer_amt`, `stat_inband` and `stat_held` are all zero.
- R2: The error is `rf_tag` minus the reference tag, taken modulo 2^TAG_W and read as two's complement. `cfg_ref` selects the reference: 0 selects `evt_utc_tag`, 1 selects `evt_rx_tag`, and 2 or 3 selects `gate_tag`.
- R3: The amount of an issued request is the negated error divided by 2^`cfg_tc_log2`, rounded toward zero. A shift large enough to give zero still produces a request with a zero amount.
- R4: A sample whose error magnitude is less than or equal to `cfg_min_steer` issues no request and sets `stat_inband`.
- R5: After a request is issued on a sample, no further request is issued until the `cfg_interval`-th valid sample after it. Values 0 and 1 both allow every sample.
- R6: The spacing count restarts only on a sample that actually issues a request. Samples held back by the dead band or by the spacing limit keep advancing the count.
- R7: Cycles with `smp_valid` low are ignored. They issue no request, leave `steer_amt`, `stat_inband` and `stat_held` unchanged, and do not advance the spacing count.
- R8: A request appears on `steer_req` in the cycle after its sample and lasts one cycle per issuing sample. `steer_amt` keeps the last issued amount until the next request.
- R9: On each valid sample, `stat_held` is set only when the error is outside the dead band but the spacing limit blocks it. `stat_inband` and `stat_held` are never both high.
- R10: After reset, the first sample outside the dead band issues a request whatever `cfg_interval` is.
- R11: The most negative error, -2^(TAG_W-1), yields a positive amount of 2^(TAG_W-1) without overflow. `steer_amt` is TAG_W+1 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One error sample is present this cycle |
| rf_tag | input | TAG_W | Time tag of the detected transmitter pulse edge |
| evt_utc_tag | input | TAG_W | Timing event tag, UTC-derived timebase |
| evt_rx_tag | input | TAG_W | Timing event tag, received-signal-derived timebase |
| gate_tag | input | TAG_W | RF gate edge tag |
| cfg_ref | input | 2 | Reference select (see R2) |
| cfg_tc_log2 | input | SH_W | Time constant as a power-of-two exponent |
| cfg_min_steer | input | TAG_W | Dead-band limit on the error magnitude |
| cfg_interval | input | CNT_W | Minimum samples between requests |
| steer_req | output | 1 | Adjustment request strobe |
| steer_amt | output | TAG_W+1 | Signed adjustment amount, held between requests |
| stat_inband | output | 1 | Last sample was inside the dead band |
| stat_held | output | 1 | Last sample was blocked by the spacing limit |

## Verification
Two cases can fall on the same sample. In the first, the spacing limit expires on the very sample whose error sits exactly at the dead-band edge, so the dead-band test and the spacing test must decide together. In the second, a new sample arrives in the same cycle that the previous sample's request is on the outputs, so the count restart and the next spacing test overlap. Back-to-back valid samples with errors near `cfg_min_steer` and small spacing values provoke both cases. A behavioural model in the bench then judges the request, amount and both flags on every clock.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    typedef enum logic [1:0] {
        REF_EVT_UTC  = 2'd0,
        REF_EVT_RX   = 2'd1,
        REF_GATE     = 2'd2,
        REF_GATE_ALT = 2'd3
    } ptc_ref_e;

    typedef struct packed {
        logic issue;
        logic inband;
        logic held;
    } ptc_dec_t;

    // Combine the dead-band and spacing verdicts for one sample.
    function automatic ptc_dec_t ptc_decide(input logic valid,
                                            input logic above,
                                            input logic allow);
        ptc_dec_t d;
        d.issue  = valid & above & allow;
        d.inband = valid & ~above;
        d.held   = valid & above & ~allow;
        return d;
    endfunction

endpackage

// File: rtl/ptc_err_sel.sv
module ptc_err_sel
    import ptc_pkg::*;
#(
    parameter int TAG_W = 24
) (
    input  logic [TAG_W-1:0] rf_tag,
    input  logic [TAG_W-1:0] evt_utc_tag,
    input  logic [TAG_W-1:0] evt_rx_tag,
    input  logic [TAG_W-1:0] gate_tag,
    input  logic [1:0]       ref_sel,
    output logic             err_neg,
    output logic [TAG_W-1:0] err_mag
);
    logic [TAG_W-1:0] ref_t;
    logic [TAG_W-1:0] diff;

    always_comb begin
        unique case (ptc_ref_e'(ref_sel))
            REF_EVT_UTC: ref_t = evt_utc_tag;
            REF_EVT_RX:  ref_t = evt_rx_tag;
            default:     ref_t = gate_tag;
        endcase
        diff    = rf_tag - ref_t;
        err_neg = diff[TAG_W-1];
        // unsigned magnitude: the most negative value maps to 2^(TAG_W-1)
        err_mag = err_neg ? (~diff + 1'b1) : diff;
    end
endmodule

// File: rtl/ptc_gain.sv
module ptc_gain #(
    parameter int TAG_W = 24,
    parameter int SH_W  = 5
) (
    input  logic                    err_neg,
    input  logic [TAG_W-1:0]        err_mag,
    input  logic [SH_W-1:0]         shift,
    output logic signed [TAG_W:0]   corr
);
    logic [TAG_W-1:0] q;

    always_comb begin
        // shifting the magnitude rounds toward zero for both signs
        q    = err_mag >> shift;
        corr = err_neg ? $signed({1'b0, q}) : -$signed({1'b0, q});
    end
endmodule

// File: rtl/ptc_rate.sv
module ptc_rate #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample,
    input  logic             issue,
    input  logic [CNT_W-1:0] interval,
    output logic             allow
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        cnt_inc = (cnt == CNT_MAX) ? CNT_MAX : cnt + 1'b1;
        allow   = (cnt_inc >= interval);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= CNT_MAX;
        end else if (sample) begin
            cnt <= issue ? '0 : cnt_inc;
        end
    end
endmodule

// File: rtl/ptc_steer_ctrl.sv
module ptc_steer_ctrl
    import ptc_pkg::*;
#(
    parameter int TAG_W = 24,
    parameter int SH_W  = 5,
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  smp_valid,
    input  logic [TAG_W-1:0]      rf_tag,
    input  logic [TAG_W-1:0]      evt_utc_tag,
    input  logic [TAG_W-1:0]      evt_rx_tag,
    input  logic [TAG_W-1:0]      gate_tag,
    input  logic [1:0]            cfg_ref,
    input  logic [SH_W-1:0]       cfg_tc_log2,
    input  logic [TAG_W-1:0]      cfg_min_steer,
    input  logic [CNT_W-1:0]      cfg_interval,
    output logic                  steer_req,
    output logic signed [TAG_W:0] steer_amt,
    output logic                  stat_inband,
    output logic                  stat_held
);
    localparam int AMT_W = TAG_W + 1;

    logic                   err_neg;
    logic [TAG_W-1:0]       err_mag;
    logic signed [AMT_W-1:0] corr;
    logic                   above;
    logic                   allow;
    ptc_dec_t               dec;

    ptc_err_sel #(.TAG_W(TAG_W)) u_sel (
        .rf_tag      (rf_tag),
        .evt_utc_tag (evt_utc_tag),
        .evt_rx_tag  (evt_rx_tag),
        .gate_tag    (gate_tag),
        .ref_sel     (cfg_ref),
        .err_neg     (err_neg),
        .err_mag     (err_mag)
    );

    ptc_gain #(.TAG_W(TAG_W), .SH_W(SH_W)) u_gain (
        .err_neg (err_neg),
        .err_mag (err_mag),
        .shift   (cfg_tc_log2),
        .corr    (corr)
    );

    assign above = (err_mag > cfg_min_steer);
    assign dec   = ptc_decide(smp_valid, above, allow);

    ptc_rate #(.CNT_W(CNT_W)) u_rate (
        .clk      (clk),
        .rst      (rst),
        .sample   (smp_valid),
        .issue    (dec.issue),
        .interval (cfg_interval),
        .allow    (allow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            steer_req   <= 1'b0;
            steer_amt   <= '0;
            stat_inband <= 1'b0;
            stat_held   <= 1'b0;
        end else begin
            steer_req <= dec.issue;
            if (dec.issue) begin
                steer_amt <= corr;
            end
            if (smp_valid) begin
                stat_inband <= dec.inband;
                stat_held   <= dec.held;
            end
        end
    end
endmodule

// File: rtl/ptc_steer_chk.sv
module ptc_steer_chk #(
    parameter int TAG_W = 24,
    parameter int CNT_W = 16
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  smp_valid,
    input logic [CNT_W-1:0]      cfg_interval,
    input logic                  steer_req,
    input logic signed [TAG_W:0] steer_amt,
    input logic                  stat_inband,
    input logic                  stat_held
);
    localparam logic [CNT_W-1:0] GAP_MAX = {CNT_W{1'b1}};

    // valid samples seen since the sample that produced the last request
    logic [CNT_W-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap <= GAP_MAX;
        end else if (steer_req) begin
            gap <= smp_valid ? {{(CNT_W-1){1'b0}}, 1'b1} : '0;
        end else if (smp_valid && gap != GAP_MAX) begin
            gap <= gap + 1'b1;
        end
    end

    AST_REQ_FROM_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        steer_req |-> $past(smp_valid)); // R7

    AST_AMT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !steer_req |-> $stable(steer_amt)); // R8

    AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(stat_inband && stat_held)); // R9

    AST_REQ_CLEAR_STATUS: assert property (@(posedge clk) disable iff (rst)
        steer_req |-> (!stat_inband && !stat_held)); // R4

    AST_SPACING: assert property (@(posedge clk) disable iff (rst)
        steer_req |-> (gap >= cfg_interval)); // R5

    AST_STATUS_IDLE: assert property (@(posedge clk) disable iff (rst)
        !$past(smp_valid) |-> ($stable(stat_inband) && $stable(stat_held))); // R7
endmodule

bind ptc_steer_ctrl ptc_steer_chk #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .smp_valid    (smp_valid),
    .cfg_interval (cfg_interval),
    .steer_req    (steer_req),
    .steer_amt    (steer_amt),
    .stat_inband  (stat_inband),
    .stat_held    (stat_held)
);

// File: tb/tb_ptc_steer_ctrl.sv
`timescale 1ns/1ps
module tb_ptc_steer_ctrl;
    localparam int TAG_W = 24;
    localparam int SH_W  = 5;
    localparam int CNT_W = 16;
    localparam longint MOD  = 64'sd1 << TAG_W;
    localparam longint HALF = 64'sd1 << (TAG_W - 1);
    localparam int CMAX = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_valid = 1'b0;
    logic [TAG_W-1:0] rf_tag = '0, evt_utc_tag = '0, evt_rx_tag = '0, gate_tag = '0;
    logic [1:0] cfg_ref = 2'd0;
    logic [SH_W-1:0] cfg_tc_log2 = '0;
    logic [TAG_W-1:0] cfg_min_steer = '0;
    logic [CNT_W-1:0] cfg_interval = '0;
    logic steer_req, stat_inband, stat_held;
    logic signed [TAG_W:0] steer_amt;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ptc_steer_ctrl #(.TAG_W(TAG_W), .SH_W(SH_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .rf_tag(rf_tag),
        .evt_utc_tag(evt_utc_tag), .evt_rx_tag(evt_rx_tag), .gate_tag(gate_tag),
        .cfg_ref(cfg_ref), .cfg_tc_log2(cfg_tc_log2), .cfg_min_steer(cfg_min_steer),
        .cfg_interval(cfg_interval), .steer_req(steer_req), .steer_amt(steer_amt),
        .stat_inband(stat_inband), .stat_held(stat_held)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference model, updated at each rising edge
    longint m_amt = 0;
    bit m_req = 0, m_in = 0, m_held = 0;
    int m_cnt = CMAX;

    always @(posedge clk) begin
        if (rst) begin
            m_req = 0; m_amt = 0; m_in = 0; m_held = 0; m_cnt = CMAX;
        end else begin
            m_req = 0;
            if (smp_valid) begin
                longint rv, e, mag, q;
                int nxt;
                bit allow, above;
                case (cfg_ref)
                    2'd0: rv = longint'(evt_utc_tag);
                    2'd1: rv = longint'(evt_rx_tag);
                    default: rv = longint'(gate_tag);
                endcase
                e = (longint'(rf_tag) - rv) % MOD;
                if (e < 0) e += MOD;
                if (e >= HALF) e -= MOD;
                mag = (e < 0) ? -e : e;
                above = mag > longint'(cfg_min_steer);
                nxt = (m_cnt == CMAX) ? CMAX : m_cnt + 1;
                allow = nxt >= int'(cfg_interval);
                q = mag / (64'sd1 << cfg_tc_log2);
                m_in = !above;
                m_held = above && !allow;
                if (above && allow) begin
                    m_req = 1;
                    m_amt = (e < 0) ? q : -q;
                    m_cnt = 0;
                end else begin
                    m_cnt = nxt;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R5 steer_req vs model", longint'(steer_req), longint'(m_req));
            chk("R3 steer_amt vs model", longint'(steer_amt), m_amt);
            chk("R4 stat_inband vs model", longint'(stat_inband), longint'(m_in));
            chk("R9 stat_held vs model", longint'(stat_held), longint'(m_held));
        end
    end

    task automatic do_reset(input int ival, input int tc, input int mn, input int rsel);
        @(negedge clk);
        rst = 1'b1;
        smp_valid = 1'b0;
        cfg_interval = CNT_W'(ival);
        cfg_tc_log2 = SH_W'(tc);
        cfg_min_steer = TAG_W'(mn);
        cfg_ref = 2'(rsel);
        repeat (3) @(negedge clk);
        chk("R1 reset req", longint'(steer_req), 0);
        chk("R1 reset amt", longint'(steer_amt), 0);
        chk("R1 reset flags", longint'({stat_inband, stat_held}), 0);
        rst = 1'b0;
    endtask

    task automatic put(input logic [TAG_W-1:0] rf, input logic [TAG_W-1:0] rv);
        rf_tag = rf;
        evt_utc_tag = TAG_W'($urandom);
        evt_rx_tag = TAG_W'($urandom);
        gate_tag = TAG_W'($urandom);
        case (cfg_ref)
            2'd0: evt_utc_tag = rv;
            2'd1: evt_rx_tag = rv;
            default: gate_tag = rv;
        endcase
    endtask

    task automatic smp(input logic [TAG_W-1:0] rf, input logic [TAG_W-1:0] rv);
        @(negedge clk);
        smp_valid = 1'b1;
        put(rf, rv);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset(1, 2, 10, 0);
        @(negedge clk);
        chk("R1 first cycle after reset", longint'(steer_req), 0);

        smp(24'd113, 24'd100);
        chk("R10 first steer after reset", longint'(steer_req), 1);
        chk("R3 +13>>2 gives -3", longint'(steer_amt), -3);
        smp(24'd87, 24'd100);
        chk("R3 -13 rounds toward zero to +3", longint'(steer_amt), 3);
        smp(24'd110, 24'd100);
        chk("R4 error equal to limit no request", longint'(steer_req), 0);
        chk("R4 in-band flag", longint'(stat_inband), 1);
        chk("R8 amount held", longint'(steer_amt), 3);
        smp(24'd89, 24'd100);
        chk("R4 just above limit requests", longint'(steer_req), 1);
        chk("R3 -11>>2 gives +2", longint'(steer_amt), 2);
        @(negedge clk);
        chk("R8 request lasts one cycle", longint'(steer_req), 0);

        cfg_ref = 2'd2;
        smp(24'd50, 24'd20);
        chk("R2 gate reference", longint'(steer_amt), -7);
        cfg_ref = 2'd1;
        smp(24'd40, 24'd60);
        chk("R2 received-timebase reference", longint'(steer_amt), 5);
        cfg_ref = 2'd0;
        smp(24'd17, 24'hFFFFFD);
        chk("R2 modular wrap", longint'(steer_amt), -5);
        cfg_tc_log2 = 5'd31;
        smp(24'd113, 24'd100);
        chk("R3 large shift still requests", longint'(steer_req), 1);
        chk("R3 large shift amount zero", longint'(steer_amt), 0);

        do_reset(3, 0, 10, 0);
        smp(24'd140, 24'd100);
        chk("R10 request with spacing 3", longint'(steer_amt), -40);
        smp(24'd140, 24'd100);
        chk("R5 blocked second sample", longint'(steer_req), 0);
        chk("R9 held flag", longint'(stat_held), 1);
        smp(24'd140, 24'd100);
        chk("R5 blocked third", longint'(steer_req), 0);
        smp(24'd140, 24'd100);
        chk("R5 issued on third after", longint'(steer_req), 1);
        smp(24'd100, 24'd100);
        chk("R6 in-band sample counted", longint'(stat_inband), 1);
        smp(24'd150, 24'd100);
        chk("R6 held sample", longint'(stat_held), 1);
        @(negedge clk);
        smp_valid = 1'b0;
        for (int i = 0; i < 10; i++) begin
            put(TAG_W'($urandom), TAG_W'($urandom));
            @(negedge clk);
            chk("R7 idle no request", longint'(steer_req), 0);
        end
        chk("R7 idle keeps held flag", longint'(stat_held), 1);
        chk("R7 idle keeps amount", longint'(steer_amt), -40);
        smp(24'd150, 24'd100);
        chk("R6 count kept across blocked samples", longint'(steer_req), 1);
        chk("R6 amount", longint'(steer_amt), -50);

        do_reset(1, 0, 0, 0);
        smp(24'd0, 24'h800000);
        chk("R11 most negative error", longint'(steer_amt), 64'sd8388608);
        smp(24'h7FFFFF, 24'd0);
        chk("R11 most positive error", longint'(steer_amt), -64'sd8388607);

        do_reset(2, 1, 20, 0);
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (i % 60 == 59) begin
                cfg_tc_log2 = SH_W'($urandom_range(0, 6));
                cfg_min_steer = TAG_W'($urandom_range(0, 40));
                cfg_ref = 2'($urandom_range(0, 3));
            end
            smp_valid = ($urandom_range(0, 9) < 7);
            if (i % 97 == 0)
                put(TAG_W'($urandom), TAG_W'($urandom));
            else
                put(TAG_W'(1000 + $urandom_range(0, 120)), TAG_W'(1060));
        end
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (3) @(negedge clk);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule